// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller for 128 pins in four banks of 32. Each pin can be an input or an output. Each bank holds a direction word, an output latch, rising- and falling-edge enable words, a sticky edge status word and two alternate-function storage words. Software changes the output latch only through separate set and clear words. It reads a level word that shows the driven value on output pins and the synchronised pad value on input pins.

Input pins pass through a two-stage synchroniser. The previous synchronised sample is kept for edge detection. An enabled edge on an input pin sets a sticky status bit, and writing a 1 clears that bit. Three interrupt lines are formed from the status. Two lines each follow one status bit of bank 0. The third line is the OR of every other status bit. A wake pulse is raised when a pin in a fixed per-bank wake set changes level while it is an input.

The register port is a plain strobe interface. A write takes effect at the clock edge that samples it. A read returns `rd_data` with `rd_valid` one cycle later. The response cannot be held back and the port takes a new request every cycle. The address is a byte offset. Only the lower 0x200 bytes of the window decode.

Top module: `gpio_ctl`

## Requirements
- R1: After reset, every register reads 0, and `pin_o`, `irq0_o`, `irq1_o`, `irqx_o`, `wake_o` and `level_rd_o` are 0.
- R2: Offsets for bank b (b = 0,1,2) are 12·g + 4·b. For bank 3 they are 0x100 + 12·g. The group g is ordered: 0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 edge status. The alternate-function low and high words of bank b are at 0x54 + 8·b and 0x58 + 8·b.
- R3: A write to a set word ORs the data into the output latch, and a write to a clear word removes the written bits. Both words read as 0.
- R4: `pin_o` bit n equals output latch AND direction for that pin (1 = output). It changes only after a write.
- R5: A level read returns the latch bit where direction is 1, and the synchronised input where direction is 0. The input reaches the level word two cycles after the pad changes.
- R6: A low-to-high change on an input pin with its rising enable set sets the pin's status bit, visible 3 clock edges after the pad change. A pin whose direction is 1 never sets status.
- R7: A high-to-low change sets status only when the falling enable is set. A change in the direction that is not enabled sets nothing.
- R8: Writing the status word clears each bit written as 1 and keeps bits written as 0. If an edge sets a bit in the same cycle that a write clears it, the bit stays set. The interrupt outputs fall only after a write.
- R9: `irq0_o` is bank 0 status bit 0. `irq1_o` is bank 0 status bit 1. `irqx_o` is the OR of all other status bits of all banks.
- R10: `wake_o` pulses for one cycle, in the same cycle that status would update, when an input pin changes level and its bit is set in the wake mask. The default masks for banks 0..3 are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F.
- R11: Offsets at or above 0x200, offsets that are not word aligned, and unused aligned offsets all read 0. Writes to offsets at or above 0x200 change nothing.
- R12: Each read gives `rd_valid` one cycle later. `level_rd_o` pulses in that same cycle only for a read of a level word.
- R13: The alternate-function words store and return any 32-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (12) | Byte offset |
| wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 32 | Read data |
| level_rd_o | output | 1 | Pulse when a level word was read |
| pin_i | input | 128 | Pad input levels |
| pin_o | output | 128 | Driven pad values |
| irq0_o | output | 1 | Interrupt for bank 0 status bit 0 |
| irq1_o | output | 1 | Interrupt for bank 0 status bit 1 |
| irqx_o | output | 1 | Combined interrupt for all other status bits |
| wake_o | output | 1 | Wake pulse |

## Verification
The bench builds the block with its default parameters. These are four banks of 32 pins, the fixed wake masks and a 12-bit address, so offsets beyond 0x200 can be reached and the alias check for out-of-window writes is meaningful. With the whole map at only 128 word offsets, the bench reads every one of them and compares each against a register model. It sweeps a rising edge, and then a falling edge, across every one of the 128 pins. For each pin it predicts the status word, the interrupt line that should rise and whether a wake pulse should appear, using arithmetic on the pin index.

// File: rtl/gpio_ctl_pkg.sv
package gpio_ctl_pkg;
  localparam int BANKS = 4;
  localparam int BW    = 32;

  typedef enum logic [3:0] {
    RK_NONE, RK_LEVEL, RK_DIR, RK_SET, RK_CLR,
    RK_RISE, RK_FALL, RK_STAT, RK_AFLO, RK_AFHI
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic [1:0]  bank;
  } reg_sel_t;

  // Offset decode within the 0x200 window. Banks 0..2 interleave by word
  // inside each group of three; bank 3 repeats the groups from 0x100.
  function automatic reg_sel_t decode_offset(input logic [8:0] ofs);
    reg_sel_t s;
    int w;
    s.kind = RK_NONE;
    s.bank = 2'd0;
    w = int'(ofs[8:2]);
    if (ofs[1:0] == 2'b00) begin
      if (w < 21) begin
        s.kind = reg_kind_e'(4'(w / 3 + 1));
        s.bank = 2'(w % 3);
      end else if (w < 29) begin
        s.kind = (((w - 21) % 2) == 0) ? RK_AFLO : RK_AFHI;
        s.bank = 2'((w - 21) / 2);
      end else if (w >= 64 && w <= 82 && ((w - 64) % 3) == 0) begin
        s.kind = reg_kind_e'(4'((w - 64) / 3 + 1));
        s.bank = 2'd3;
      end
    end
    return s;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] lvl_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad_i;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign lvl_o  = lvl_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_ctl_pkg::*;
#(
  parameter int           W    = 32,
  parameter logic [W-1:0] WAKE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  reg_kind_e    wr_kind,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] prev_i,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] aflo_o,
  output logic [W-1:0] afhi_o,
  output logic [W-1:0] view_o,
  output logic [W-1:0] drive_o,
  output logic         wake_o
);
  logic [W-1:0] dir_q, out_q, rise_q, fall_q, stat_q, aflo_q, afhi_q;
  logic [W-1:0] up, dn, set_v, clr_v;

  assign up    = lvl_i & ~prev_i;
  assign dn    = ~lvl_i & prev_i;
  assign set_v = ~dir_q & ((up & rise_q) | (dn & fall_q));
  assign clr_v = (wr_en && wr_kind == RK_STAT) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      stat_q <= '0;
      aflo_q <= '0;
      afhi_q <= '0;
    end else begin
      // set dominates clear on a coincident bit
      stat_q <= (stat_q & ~clr_v) | set_v;
      if (wr_en) begin
        case (wr_kind)
          RK_DIR:  dir_q  <= wdata;
          RK_SET:  out_q  <= out_q | wdata;
          RK_CLR:  out_q  <= out_q & ~wdata;
          RK_RISE: rise_q <= wdata;
          RK_FALL: fall_q <= wdata;
          RK_AFLO: aflo_q <= wdata;
          RK_AFHI: afhi_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  assign dir_o   = dir_q;
  assign rise_o  = rise_q;
  assign fall_o  = fall_q;
  assign stat_o  = stat_q;
  assign aflo_o  = aflo_q;
  assign afhi_o  = afhi_q;
  assign drive_o = out_q & dir_q;
  assign view_o  = (out_q & dir_q) | (lvl_i & ~dir_q);
  assign wake_o  = |((lvl_i ^ prev_i) & ~dir_q & WAKE);
endmodule

// File: rtl/gpio_irq_reduce.sv
module gpio_irq_reduce #(
  parameter int N = 128
) (
  input  logic [N-1:0] stat_i,
  output logic         irq0_o,
  output logic         irq1_o,
  output logic         irqx_o
);
  assign irq0_o = stat_i[0];
  assign irq1_o = stat_i[1];
  assign irqx_o = |stat_i[N-1:2];
endmodule

// File: rtl/gpio_ctl.sv
module gpio_ctl
  import gpio_ctl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [BANKS*BW-1:0] WAKE_MASK =
    {32'h0012007F, 32'hEC080000, 32'h002001FC, 32'h8003FE1B}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BW-1:0]       wdata,
  output logic                rd_valid,
  output logic [BW-1:0]       rd_data,
  output logic                level_rd_o,
  input  logic [BANKS*BW-1:0] pin_i,
  output logic [BANKS*BW-1:0] pin_o,
  output logic                irq0_o,
  output logic                irq1_o,
  output logic                irqx_o,
  output logic                wake_o
);
  localparam int PINS = BANKS * BW;

  logic           in_win;
  reg_sel_t       sel;
  logic           wr_hit;
  logic [BW-1:0]  dir_w  [BANKS];
  logic [BW-1:0]  rise_w [BANKS];
  logic [BW-1:0]  fall_w [BANKS];
  logic [BW-1:0]  stat_w [BANKS];
  logic [BW-1:0]  aflo_w [BANKS];
  logic [BW-1:0]  afhi_w [BANKS];
  logic [BW-1:0]  view_w [BANKS];
  logic [BANKS-1:0] wake_w;
  logic [PINS-1:0]  stat_flat;
  logic [BW-1:0]    rd_next;

  assign in_win = (addr[ADDR_W-1:9] == '0);
  assign sel    = decode_offset(addr[8:0]);
  assign wr_hit = wr_en && in_win && (sel.kind != RK_NONE);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [BW-1:0] lvl, prev;
    logic          bank_we;
    assign bank_we = wr_hit && (sel.bank == 2'(b));

    gpio_in_sync #(.W(BW)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pad_i  (pin_i[b*BW +: BW]),
      .lvl_o  (lvl),
      .prev_o (prev)
    );

    gpio_bank #(.W(BW), .WAKE(WAKE_MASK[b*BW +: BW])) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bank_we),
      .wr_kind (sel.kind),
      .wdata   (wdata),
      .lvl_i   (lvl),
      .prev_i  (prev),
      .dir_o   (dir_w[b]),
      .rise_o  (rise_w[b]),
      .fall_o  (fall_w[b]),
      .stat_o  (stat_w[b]),
      .aflo_o  (aflo_w[b]),
      .afhi_o  (afhi_w[b]),
      .view_o  (view_w[b]),
      .drive_o (pin_o[b*BW +: BW]),
      .wake_o  (wake_w[b])
    );

    assign stat_flat[b*BW +: BW] = stat_w[b];
  end

  gpio_irq_reduce #(.N(PINS)) u_irq (
    .stat_i (stat_flat),
    .irq0_o (irq0_o),
    .irq1_o (irq1_o),
    .irqx_o (irqx_o)
  );

  always_comb begin
    rd_next = '0;
    if (in_win) begin
      case (sel.kind)
        RK_LEVEL: rd_next = view_w[sel.bank];
        RK_DIR:   rd_next = dir_w[sel.bank];
        RK_RISE:  rd_next = rise_w[sel.bank];
        RK_FALL:  rd_next = fall_w[sel.bank];
        RK_STAT:  rd_next = stat_w[sel.bank];
        RK_AFLO:  rd_next = aflo_w[sel.bank];
        RK_AFHI:  rd_next = afhi_w[sel.bank];
        default:  rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      level_rd_o <= 1'b0;
      wake_o     <= 1'b0;
    end else begin
      rd_valid   <= rd_en;
      rd_data    <= rd_en ? rd_next : '0;
      level_rd_o <= rd_en && in_win && (sel.kind == RK_LEVEL);
      wake_o     <= |wake_w;
    end
  end
endmodule

// File: rtl/gpio_ctl_chk.sv
module gpio_ctl_chk #(
  parameter int ADDR_W = 12,
  parameter int PINS   = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_valid,
  input logic [31:0]       rd_data,
  input logic              level_rd_o,
  input logic [PINS-1:0]   pin_o,
  input logic              irq0_o,
  input logic              irq1_o,
  input logic              irqx_o
);
  AST_RD_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R12
  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!rd_valid && rd_data == '0)); // R12
  AST_STROBE_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    level_rd_o |-> rd_valid); // R12
  AST_PIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(pin_o)); // R4
  AST_IRQ_DROP_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(irq0_o) || $fell(irq1_o) || $fell(irqx_o)) |-> $past(wr_en)); // R8
  AST_OUT_OF_WINDOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(addr[ADDR_W-1:9] != '0)) |-> (rd_data == '0)); // R11
endmodule

bind gpio_ctl gpio_ctl_chk #(.ADDR_W(ADDR_W), .PINS(PINS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .addr       (addr),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .level_rd_o (level_rd_o),
  .pin_o      (pin_o),
  .irq0_o     (irq0_o),
  .irq1_o     (irq1_o),
  .irqx_o     (irqx_o)
);

// File: tb/gpio_ctl_bench.sv
`timescale 1ns/1ps
module gpio_ctl_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [11:0]  addr = '0;
  logic [31:0]  wdata = '0;
  logic         rd_valid;
  logic [31:0]  rd_data;
  logic         level_rd;
  logic [127:0] pins = '0;
  logic [127:0] pin_o;
  logic         irq0, irq1, irqx, wake;

  int nchk = 0;
  int nerr = 0;
  int wcnt = 0;
  logic [31:0] model [9][4];
  logic [127:0] wmask = {32'h0012007F, 32'hEC080000, 32'h002001FC, 32'h8003FE1B};

  always #10 clk = ~clk;  // 50 MHz

  gpio_ctl u_gpio_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_valid(rd_valid), .rd_data(rd_data), .level_rd_o(level_rd),
    .pin_i(pins), .pin_o(pin_o), .irq0_o(irq0), .irq1_o(irq1), .irqx_o(irqx),
    .wake_o(wake)
  );

  always @(negedge clk) if (wake) wcnt++;

  function automatic logic [11:0] a_of(int g, int b);
    if (g >= 7) return 12'(32'h54 + 8 * b + 4 * (g - 7));
    if (b < 3) return 12'(12 * g + 4 * b);
    return 12'(256 + 12 * g);
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d, output logic s);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    d = rd_valid ? rd_data : 32'hDEAD_BEEF;
    s = level_rd;
  endtask

  task automatic settle(); repeat (3) @(negedge clk); endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic s;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 pins", pin_o, '0);
    chk("R1 irq/wake", {irq0, irq1, irqx, wake, level_rd}, '0);
    for (int g = 0; g < 9; g++)
      for (int b = 0; b < 4; b++) begin
        model[g][b] = '0;
        rd(a_of(g, b), d, s);
        chk("R1 reg", d, '0);
      end

    // R13/R2: program read-write words with distinct values
    for (int b = 0; b < 4; b++) begin
      foreach (model[g]) begin
        if (g == 1 || g == 4 || g == 5 || g == 7 || g == 8) begin
          model[g][b] = 32'h9E3779B9 * (g * 4 + b + 1);
          wr(a_of(g, b), model[g][b]);
        end
      end
    end
    for (int b = 0; b < 4; b++) begin
      rd(a_of(7, b), d, s); chk("R13 af low", d, model[7][b]);
      rd(a_of(8, b), d, s); chk("R13 af high", d, model[8][b]);
    end

    // R2/R11: full sweep of aligned word offsets in the window
    for (int w = 0; w < 128; w++) begin
      logic [31:0] e;
      e = '0;
      for (int g = 0; g < 9; g++)
        for (int b = 0; b < 4; b++)
          if (a_of(g, b) == 12'(w * 4)) e = model[g][b];
      rd(12'(w * 4), d, s);
      chk("R2 R11 map", d, e);
    end
    rd(12'h00D, d, s); chk("R11 unaligned", d, '0);
    rd(12'h132, d, s); chk("R11 unaligned", d, '0);
    rd(12'h210, d, s); chk("R11 out of window read", d, '0);
    wr(12'h210, 32'hFFFF_FFFF);
    rd(a_of(1, 1), d, s); chk("R11 out of window write", d, model[1][1]);

    // clean up enables and direction
    for (int b = 0; b < 4; b++) begin
      wr(a_of(4, b), '0); wr(a_of(5, b), '0); wr(a_of(1, b), '0);
      wr(a_of(6, b), 32'hFFFF_FFFF);
    end

    // R3 R4 R5 R12: outputs and level view
    for (int b = 0; b < 4; b++) begin
      logic [31:0] dv, o, p;
      dv = 32'hFFFF0000 ^ (32'h0F0F0F0F << b);
      o  = (32'hF0F01234 ^ (32'h11111111 * b)) & ~32'h00001200;
      p  = 32'h3C5A96A5 + 32'(b);
      wr(a_of(1, b), dv);
      wr(a_of(2, b), 32'hF0F01234 ^ (32'h11111111 * b));
      wr(a_of(3, b), 32'h00001200);
      chk("R4 drive", pin_o[b*32 +: 32], o & dv);
      pins[b*32 +: 32] = p;
      settle();
      rd(a_of(0, b), d, s);
      chk("R5 level mix", d, (o & dv) | (p & ~dv));
      chk("R12 level strobe", s, 1'b1);
      rd(a_of(2, b), d, s); chk("R3 set reads 0", d, '0);
      chk("R12 no strobe", s, 1'b0);
      rd(a_of(3, b), d, s); chk("R3 clear reads 0", d, '0);
      wr(a_of(3, b), 32'hFFFF_FFFF);
      chk("R3 R4 clear all", pin_o[b*32 +: 32], '0);
      wr(a_of(1, b), '0);
    end
    pins = '0;
    settle();
    for (int b = 0; b < 4; b++) wr(a_of(6, b), 32'hFFFF_FFFF);
    chk("R8 all cleared", {irq0, irq1, irqx}, '0);

    // R6 R9 R10: rising sweep over every pin
    for (int b = 0; b < 4; b++) wr(a_of(4, b), 32'hFFFF_FFFF);
    for (int n = 0; n < 128; n++) begin
      int b, k;
      b = n / 32; k = n % 32;
      wcnt = 0;
      @(negedge clk); pins[n] = 1'b1;
      settle();
      chk("R9 irq lines", {irq0, irq1, irqx}, {n == 0, n == 1, n > 1});
      rd(a_of(6, b), d, s);
      chk("R6 rising status", d, 32'h1 << k);
      chk("R10 wake on rise", wcnt, wmask[n] ? 1 : 0);
      wr(a_of(6, b), 32'h1 << k);
      rd(a_of(6, b), d, s); chk("R8 w1c", d, '0);
      @(negedge clk); pins[n] = 1'b0;
      settle();
      rd(a_of(6, b), d, s); chk("R7 fall disabled", d, '0);
      chk("R10 wake on fall", wcnt, wmask[n] ? 2 : 0);
    end

    // R7: falling sweep over every pin
    for (int b = 0; b < 4; b++) begin
      wr(a_of(4, b), '0); wr(a_of(5, b), 32'hFFFF_FFFF);
    end
    for (int n = 0; n < 128; n++) begin
      int b, k;
      b = n / 32; k = n % 32;
      @(negedge clk); pins[n] = 1'b1;
      settle();
      rd(a_of(6, b), d, s); chk("R6 rise disabled", d, '0);
      @(negedge clk); pins[n] = 1'b0;
      settle();
      rd(a_of(6, b), d, s); chk("R7 falling status", d, 32'h1 << k);
      wr(a_of(6, b), 32'hFFFF_FFFF);
    end

    // R6 R10: output pins never set status or wake
    wr(a_of(4, 1), 32'hFFFF_FFFF);
    wr(a_of(1, 1), 32'hFFFF_FFFF);
    wcnt = 0;
    @(negedge clk); pins[40] = 1'b1;
    settle();
    @(negedge clk); pins[40] = 1'b0;
    settle();
    rd(a_of(6, 1), d, s); chk("R6 output pin ignored", d, '0);
    chk("R10 output pin no wake", wcnt, 0);
    wr(a_of(1, 1), '0);

    // R8: set wins over a coincident clear
    wr(a_of(4, 0), 32'hFFFF_FFFF);
    @(negedge clk); pins[5] = 1'b1;
    settle();
    rd(a_of(6, 0), d, s); chk("R8 pre set", d, 32'h20);
    @(negedge clk); pins[5] = 1'b0;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; addr = a_of(6, 0); wdata = 32'h20;
    @(negedge clk); wr_en = 1'b0;
    rd(a_of(6, 0), d, s); chk("R8 set wins", d, 32'h20);
    chk("R9 irqx held", irqx, 1'b1);
    wr(a_of(6, 0), 32'h0000_0000);
    rd(a_of(6, 0), d, s); chk("R8 zero write keeps", d, 32'h20);
    wr(a_of(6, 0), 32'h20);
    rd(a_of(6, 0), d, s); chk("R8 clear", d, '0);
    chk("R9 irqx low", irqx, 1'b0);

    finish_run();
  end
endmodule